// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block is a byte-wide instruction buffer that sits between a 32-bit memory bus and an instruction consumer. It keeps its storage topped up by requesting aligned doublewords from the bus whenever four or more byte slots are free. It stores the returned bytes without looking at them, and it hands them to the consumer one byte per cycle through a valid/ready pair.

Execution-side data accesses have priority on the bus. While one is pending, the block withdraws its request. A taken control transfer does three things: it empties the storage, it marks any fetch still in flight as stale, and it restarts fetching at the target address. A branch that resolves as not taken leaves everything as it was.

Every granted fetch records an epoch tag. A return whose tag no longer matches the current epoch is thrown away. When the target is misaligned, the bytes of the first doubleword that lie below the target are skipped.

Top module: `pfq_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is low, and `bus_addr` equals the parameter `RESET_ADDR` with its two low bits cleared.
- R2: `bus_req` is high exactly when no fetch is outstanding, `exec_pend` is low, and at most `DEPTH`-4 bytes are stored. Stored bytes never exceed `DEPTH`.
- R3: In any cycle where `exec_pend` is high, `bus_req` is low in that same cycle.
- R4: The bytes of a kept word are delivered in ascending address order. Lane `bus_rdata[8k+7:8k]` holds the byte at word address + k. Byte values are never inspected.
- R5: `out_valid` is high whenever at least one byte is stored. Each cycle with `out_valid` and `out_ready` both high, and no taken redirect, consumes exactly one byte.
- R6: A cycle with `redir_valid` and `redir_taken` both high empties the queue, so `out_valid` is low in the next cycle. The next request address is `redir_target` with bits [1:0] cleared. A byte offered in that same cycle is discarded even if `out_ready` is high.
- R7: A fetch granted before or during a taken redirect is dropped when it returns, and it pushes no bytes. This also applies to a return that arrives in the redirect cycle itself.
- R8: A redirect with `redir_taken` low changes neither the stored bytes, the delivered stream, nor the fetch address.
- R9: After a taken redirect to a target with low bits s, the first kept word supplies only lanes s..3. The first byte delivered is the byte at the target address.
- R10: The fetch address advances by 4 after each kept return. It holds steady while a request waits for `bus_grant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | output | 1 | Doubleword fetch request |
| bus_addr | output | ADDR_W | Word-aligned fetch address |
| bus_grant | input | 1 | Bus accepts the request this cycle |
| bus_rvalid | input | 1 | Return data valid for the outstanding fetch |
| bus_rdata | input | 32 | Returned doubleword, lowest address in bits [7:0] |
| exec_pend | input | 1 | Execution data access waiting for the bus |
| redir_valid | input | 1 | A control transfer resolved this cycle |
| redir_taken | input | 1 | The resolved transfer is taken |
| redir_target | input | ADDR_W | Byte address to restart from |
| out_valid | output | 1 | A byte is available |
| out_byte | output | 8 | Head byte |
| out_ready | input | 1 | Consumer takes the head byte |

## Verification
Three events can land on the same clock edge: a taken redirect, a bus return or grant, and a consumer pop. The bench drives redirects at random, with random grant and return latencies and a random ready pattern, so all three coincide often. Directed cases add redirects while a fetch is outstanding.

In each such cycle, the bench model applies the stated precedence. The flush wins, the return is dropped as stale, and the pop is discarded. The model then compares every later byte, request and address against its own count of stored bytes and its own expected byte address.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
   localparam int unsigned PFQ_LANES  = 4;
   localparam int unsigned PFQ_WORD_W = 8 * PFQ_LANES;
   typedef logic [7:0]   pfq_byte_t;
   typedef logic [2:0]   pfq_lcnt_t;
   typedef logic [1:0]   pfq_skip_t;
endpackage

// File: rtl/pfq_lane_align.sv
module pfq_lane_align
   import pfq_pkg::*;
(
   input  logic [PFQ_WORD_W-1:0] word_i,
   input  pfq_skip_t             skip_i,
   output logic [PFQ_WORD_W-1:0] packed_o,
   output pfq_lcnt_t             cnt_o
);
   // Lanes below the skip point are discarded, the rest slide down to lane 0.
   for (genvar g = 0; g < PFQ_LANES; g++) begin : g_lane
      always_comb begin
         packed_o[8*g +: 8] = 8'h00;
         for (int s = 0; s < PFQ_LANES; s++) begin
            if (skip_i == pfq_skip_t'(s) && (g + s) < PFQ_LANES)
               packed_o[8*g +: 8] = word_i[8*(g+s) +: 8];
         end
      end
   end
   assign cnt_o = pfq_lcnt_t'(PFQ_LANES) - {1'b0, skip_i};
endmodule

// File: rtl/pfq_byte_ring.sv
module pfq_byte_ring
   import pfq_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  pfq_lcnt_t             push_cnt,
   input  logic [PFQ_WORD_W-1:0] push_word,
   input  logic                  pop,
   output pfq_byte_t             head,
   output logic [CNT_W-1:0]      occ
);
   pfq_byte_t        store [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         wr_ptr <= wr_ptr + PTR_W'(push_cnt);
         rd_ptr <= rd_ptr + PTR_W'(pop);
         occ    <= occ + CNT_W'(push_cnt) - CNT_W'(pop);
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < PFQ_LANES; i++) begin
         if (!flush && pfq_lcnt_t'(i) < push_cnt)
            store[wr_ptr + PTR_W'(i)] <= push_word[8*i +: 8];
      end
   end

   assign head = store[rd_ptr];
endmodule

// File: rtl/pfq_fetch_ctl.sv
module pfq_fetch_ctl
   import pfq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned EPOCH_W    = 2,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  occ,
   input  logic              exec_pend,
   input  logic              grant,
   input  logic              rvalid,
   input  logic              flush,
   input  logic [ADDR_W-1:0] target,
   output logic              req,
   output logic [ADDR_W-1:0] addr,
   output logic              keep,
   output pfq_skip_t         skip,
   output logic              busy
);
   logic [EPOCH_W-1:0] cur_ep, req_ep;

   assign req  = !busy && !exec_pend && (occ <= CNT_W'(DEPTH - PFQ_LANES));
   assign keep = rvalid && busy && (req_ep == cur_ep) && !flush;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr   <= {RESET_ADDR[ADDR_W-1:2], 2'b00};
         skip   <= RESET_ADDR[1:0];
         cur_ep <= '0;
      end else if (flush) begin
         addr   <= {target[ADDR_W-1:2], 2'b00};
         skip   <= target[1:0];
         cur_ep <= cur_ep + 1'b1;
      end else if (keep) begin
         addr   <= addr + ADDR_W'(PFQ_LANES);
         skip   <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         req_ep <= '0;
      end else if (req && grant) begin
         busy   <= 1'b1;
         req_ep <= cur_ep;
      end else if (rvalid) begin
         busy   <= 1'b0;
      end
   end
endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
   import pfq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned EPOCH_W = 2,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_grant,
   input  logic              bus_rvalid,
   input  logic [31:0]       bus_rdata,
   input  logic              exec_pend,
   input  logic              redir_valid,
   input  logic              redir_taken,
   input  logic [ADDR_W-1:0] redir_target,
   output logic              out_valid,
   output logic [7:0]        out_byte,
   input  logic              out_ready
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 * PFQ_LANES || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pfq_ctrl: DEPTH must be a power of two of at least 8");
   end
   if (EPOCH_W < 1 || ADDR_W < 3) begin : g_bad_width
      $error("pfq_ctrl: EPOCH_W >= 1 and ADDR_W >= 3 required");
   end

   logic                  flush, pop, keep, fetch_busy;
   pfq_skip_t             skip;
   pfq_lcnt_t             lane_cnt, push_cnt;
   logic [PFQ_WORD_W-1:0] lane_word;
   logic [CNT_W-1:0]      occ;

   assign flush    = redir_valid && redir_taken;
   assign out_valid = (occ != '0);
   assign pop      = out_valid && out_ready && !flush;
   assign push_cnt = keep ? lane_cnt : '0;

   pfq_fetch_ctl #(
      .ADDR_W(ADDR_W), .DEPTH(DEPTH), .EPOCH_W(EPOCH_W), .RESET_ADDR(RESET_ADDR)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .occ(occ), .exec_pend(exec_pend),
      .grant(bus_grant), .rvalid(bus_rvalid), .flush(flush), .target(redir_target),
      .req(bus_req), .addr(bus_addr), .keep(keep), .skip(skip), .busy(fetch_busy)
   );

   pfq_lane_align u_align (
      .word_i(bus_rdata), .skip_i(skip), .packed_o(lane_word), .cnt_o(lane_cnt)
   );

   pfq_byte_ring #(.DEPTH(DEPTH)) u_ring (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push_cnt(push_cnt),
      .push_word(lane_word), .pop(pop), .head(out_byte), .occ(occ)
   );
endmodule

// File: rtl/pfq_ctrl_chk.sv
module pfq_ctrl_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
)(
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_grant,
   input logic              bus_rvalid,
   input logic              exec_pend,
   input logic              redir_valid,
   input logic              redir_taken,
   input logic [ADDR_W-1:0] redir_target,
   input logic              out_valid,
   input logic [CNT_W-1:0]  occ,
   input logic              fetch_busy
);
   assert_pend_yields_R3: assert property (@(posedge clk) disable iff (!rst_n)
      exec_pend |-> !bus_req);
   assert_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> occ <= CNT_W'(DEPTH - 4));
   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH));
   assert_single_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_busy |-> !bus_req);
   assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (redir_valid && redir_taken) |=> !out_valid);
   assert_flush_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (redir_valid && redir_taken) |=>
         (bus_addr[ADDR_W-1:2] == $past(redir_target[ADDR_W-1:2]) && bus_addr[1:0] == 2'b00));
   assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_grant && !(redir_valid && redir_taken)) |=> $stable(bus_addr));
   assert_not_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (redir_valid && !redir_taken && !bus_rvalid) |=> $stable(bus_addr));
endmodule

bind pfq_ctrl pfq_ctrl_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
   .bus_grant(bus_grant), .bus_rvalid(bus_rvalid), .exec_pend(exec_pend),
   .redir_valid(redir_valid), .redir_taken(redir_taken), .redir_target(redir_target),
   .out_valid(out_valid), .occ(occ), .fetch_busy(fetch_busy)
);

// File: tb/tb_pfq_ctrl.sv
`timescale 1ns/1ps
module tb_pfq_ctrl;
   localparam int unsigned AW    = 32;
   localparam int unsigned DEPTH = 16;
   localparam logic [AW-1:0] RST_A = 32'h0000_0102;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_req, bus_grant = 1'b0, bus_rvalid = 1'b0;
   logic [AW-1:0] bus_addr;
   logic [31:0]   bus_rdata = '0;
   logic          exec_pend = 1'b0, redir_valid = 1'b0, redir_taken = 1'b0;
   logic [AW-1:0] redir_target = '0;
   logic          out_valid, out_ready = 1'b0;
   logic [7:0]    out_byte;

   always #2 clk = ~clk;

   pfq_ctrl #(.ADDR_W(AW), .DEPTH(DEPTH), .RESET_ADDR(RST_A)) dut (.*);

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // knobs (percent) and one-shot forced redirect
   int p_pend = 0, p_redir = 0, p_ready = 0, p_gnt = 100, p_taken = 50;
   bit f_redir = 0, f_taken = 0;
   logic [AW-1:0] f_tgt = '0;

   // bench model
   int            occ_m = 0;
   logic [AW-1:0] fa_m, pc_m, ret_addr;
   logic [1:0]    skip_m;
   bit            busy_m = 0, stale_m = 0, flushed_last = 0;
   int            ret_cnt = 0;
   string         lbl = "R1";

   function automatic logic [7:0] mb(input logic [AW-1:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
   endfunction
   function automatic logic [31:0] mword(input logic [AW-1:0] a);
      return {mb(a + 3), mb(a + 2), mb(a + 1), mb(a)};
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic one_cycle();
      bit rt, fire, kept, rv, gn, exp_req;
      logic [AW-1:0] tgt;
      @(negedge clk);
      exec_pend = ($urandom % 100) < p_pend;
      out_ready = ($urandom % 100) < p_ready;
      if (f_redir) begin
         redir_valid = 1'b1; redir_taken = f_taken; tgt = f_tgt; f_redir = 0;
      end else begin
         redir_valid = ($urandom % 100) < p_redir;
         redir_taken = ($urandom % 100) < p_taken;
         tgt = $urandom & 32'h0000_FFFF;
      end
      redir_target = tgt;
      rt = redir_valid && redir_taken;
      rv = busy_m && ret_cnt == 0;
      bus_rvalid = rv;
      bus_rdata  = rv ? mword(ret_addr) : 32'hDEAD_BEEF;
      #1;
      chk(out_valid == (occ_m != 0), flushed_last ? "R6 empty after flush" : "R5 valid",
          32'(out_valid), 32'(occ_m != 0));
      exp_req = !busy_m && !exec_pend && occ_m <= DEPTH - 4;
      chk(bus_req == exp_req, exec_pend ? "R3 yield" : "R2 request", 32'(bus_req), 32'(exp_req));
      if (bus_req)
         chk(bus_addr == fa_m, flushed_last ? "R6 target" : "R10 address", bus_addr, fa_m);
      gn = bus_req && (($urandom % 100) < p_gnt);
      bus_grant = gn;
      fire = out_valid && out_ready && !rt;
      if (fire) begin
         chk(out_byte == mb(pc_m), lbl, 32'(out_byte), 32'(mb(pc_m)));
         lbl = "R4";
      end
      // model update for the coming edge
      kept = rv && !stale_m && !rt;
      flushed_last = rt;
      if (rt) begin
         occ_m = 0; fa_m = {tgt[AW-1:2], 2'b00}; skip_m = tgt[1:0]; pc_m = tgt;
         if (busy_m && !rv) stale_m = 1;
         lbl = (busy_m && !rv) || gn ? "R7 stale drop" : (tgt[1:0] != 0 ? "R9 misaligned" : "R6 restart");
      end else begin
         if (kept) begin occ_m += 4 - skip_m; skip_m = 0; fa_m += 4; end
         if (fire) begin occ_m--; pc_m++; end
         if (redir_valid) lbl = "R8 not taken";
      end
      if (rv) begin busy_m = 0; stale_m = 0; end
      else if (busy_m) ret_cnt--;
      if (gn) begin busy_m = 1; stale_m = rt; ret_addr = bus_addr; ret_cnt = $urandom % 3; end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) one_cycle();
   endtask

   initial begin : watchdog
      #(4 * 190000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5678));
      fa_m = {RST_A[AW-1:2], 2'b00}; skip_m = RST_A[1:0]; pc_m = RST_A;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 reset valid", 32'(out_valid), 0);
      rst_n = 1'b1;
      #1;
      chk(bus_addr == fa_m, "R1 reset addr", bus_addr, fa_m);
      chk(out_valid == 1'b0, "R1 reset empty", 32'(out_valid), 0);
      lbl = "R9 reset skip";
      // fill to capacity with no consumer (R2)
      p_ready = 0; run(40);
      chk(occ_m > DEPTH - 4, "R2 full", occ_m, DEPTH);
      // drain
      p_ready = 100; run(30);
      // pending data accesses block fetching (R3)
      p_pend = 100; run(10); p_pend = 0;
      // taken redirect while a fetch is in flight (R7) and misaligned (R9)
      p_gnt = 100;
      for (int k = 0; k < 6; k++) begin
         run(3);
         f_redir = 1; f_taken = 1; f_tgt = 32'h0000_2000 + 32'(k * 37);
         run(12);
         f_redir = 1; f_taken = 0; f_tgt = 32'h0000_9000;   // R8
         run(12);
      end
      // random mix
      p_pend = 20; p_redir = 4; p_ready = 70; p_gnt = 70;
      run(4000);
      p_ready = 30; p_gnt = 40; p_redir = 8;
      run(3000);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule